// File: doc/BRIEF.md
# Prioritised Maskable Interrupt Controller

This block sits between a processor core and a set of interrupt sources: external pins, on-chip peripherals and a power-down request. Each source is either level-sensitive, edge-sensitive, or selectable between the two through a control register. Edge-sensitive requests are caught in a per-source latch. Level requests are passed straight through while the pin stays high.

Pending requests are gated by an individual mask register and a global enable. The block then offers the core the single highest-priority survivor as a valid flag and a vector index. The core takes a request with a one-cycle `ack_i` and ends its service routine with a one-cycle `rti_i`. An in-service record decides whether a new request may preempt the current one (nesting on) or must wait for the return (nesting off).

Software can set or drop edge latches through a write-only force/clear port. Every write to the mask register blanks the output for one cycle. Source 0 is the power-down request. It is edge-sensitive and ignores the mask register.

Top module: `irqc_top`

## Requirements
- R1: After reset the global enable is on, every mask bit is 0 (masked), the control register is 0 and no request is presented, even when a maskable level source is high.
- R2: A maskable source is presented only when its bit in the mask register is 1. A mask bit of 0 hides it.
- R3: When several eligible requests are pending, the one with the lowest source index is presented, and `irq_vec_o` carries that index in binary.
- R4: In the cycle after any mask-register write, `irq_valid_o` is 0 whatever is pending. In the following cycle normal selection resumes.
- R5: A level source (fixed sources 2, 3, 9, or a configurable source in level mode) is pending exactly while its input is high. Nothing is latched.
- R6: An edge source (fixed sources 0, 4, 7, 8, or a configurable source in edge mode) latches a rising input edge. The request stays pending after the input falls, until the request is acknowledged or cleared.
- R7: Control register bit 0 selects edge mode for source 1, bit 1 for source 5 and bit 2 for source 6 (1 = edge, 0 = level). Bit 3 enables nesting.
- R8: A force/clear write sets the latch of each edge-mode source whose force bit is 1 and drops the latch of each source whose clear bit is 1, with clear winning. Force bits on level-mode sources have no effect.
- R9: Source 0 (power-down) is presented even when its mask bit is 0.
- R10: A global disable command blocks every request, source 0 included. A global enable command restores presentation of still-pending requests.
- R11: With nesting off, nothing is presented while a request is in service. With nesting on, only sources with a lower index than every source in service are presented.
- R12: An acknowledge of a presented request clears that source's edge latch and marks it in service. A return ends the most recently taken (lowest-index) service.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_i | input | NSRC | Raw request inputs, index = priority (0 highest) |
| msk_we_i | input | 1 | Mask register write strobe |
| msk_wdata_i | input | NSRC | Mask value, 1 = enabled |
| ctl_we_i | input | 1 | Control register write strobe |
| ctl_wdata_i | input | 4 | Edge selects for configurable sources and nesting enable |
| fc_we_i | input | 1 | Force/clear write strobe |
| fc_force_i | input | NSRC | Latch force bits |
| fc_clear_i | input | NSRC | Latch clear bits |
| gie_set_i | input | 1 | Global enable command |
| gie_clr_i | input | 1 | Global disable command (wins over enable) |
| ack_i | input | 1 | Core takes the presented request |
| rti_i | input | 1 | Core returns from a service routine |
| irq_valid_o | output | 1 | A request is presented |
| irq_vec_o | output | 4 | Index of the presented request |

## Verification
Level stimulus, where an input is raised and dropped, tells pass-through from latching. Pulsed stimulus on fixed-edge, configurable and power-down sources shows that a request survives the input falling, and that the acknowledge or a clear removes it. Overlapping requests from two sources show that the lowest index wins and that the next one surfaces when the winner drops. Ack/return sequences with nesting off and on, including a power-down request arriving during a lower service, separate the two service disciplines.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

  typedef enum logic [1:0] {
    SRC_LEVEL = 2'd0,
    SRC_EDGE  = 2'd1,
    SRC_CFG   = 2'd2
  } src_kind_e;

  // number of configurable sources among indices below n
  function automatic int count_cfg(input logic [63:0] kinds, input int n);
    int c;
    c = 0;
    for (int j = 0; j < n; j++) begin
      if (kinds[2*j +: 2] == SRC_CFG) c++;
    end
    return c;
  endfunction

endpackage

// File: rtl/irqc_src.sv
module irqc_src (
  input  logic clk,
  input  logic rst_n,
  input  logic irq_i,
  input  logic edge_mode_i,
  input  logic force_i,
  input  logic clear_i,
  input  logic take_i,
  output logic pend_o
);

  logic prev_q;
  logic lat_q, lat_d, lat_en;
  logic rise;

  assign rise = irq_i & ~prev_q;

  always_comb begin
    lat_d = lat_q;
    if (!edge_mode_i)          lat_d = 1'b0;
    else if (clear_i)          lat_d = 1'b0;
    else if (rise || force_i)  lat_d = 1'b1;
    else if (take_i)           lat_d = 1'b0;
  end

  assign lat_en = (lat_d != lat_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= irq_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      lat_q <= 1'b0;
    else if (lat_en) lat_q <= lat_d;
  end

  assign pend_o = edge_mode_i ? lat_q : irq_i;

  // R6: a latched edge request persists while nothing removes it
  p_edge_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_mode_i && pend_o && !clear_i && !take_i) |=> (!edge_mode_i || pend_o));

  // R8: clear drops the latch of an edge source
  p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_mode_i && clear_i) |=> (!edge_mode_i || !lat_q));

  // R8: force without clear sets the latch
  p_force_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_mode_i && force_i && !clear_i) |=> (!edge_mode_i || pend_o));

endmodule

// File: rtl/irqc_pick.sv
module irqc_pick #(
  parameter int NSRC = 10,
  localparam int VW = (NSRC > 1) ? $clog2(NSRC) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] req_i,
  output logic            valid_o,
  output logic [VW-1:0]   idx_o
);

  always_comb begin
    valid_o = 1'b0;
    idx_o   = '0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        valid_o = 1'b1;
        idx_o   = VW'(i);
      end
    end
  end

  // R3: winner is pending and no lower index is pending
  p_lowest_wins_r3: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> (req_i[idx_o] &&
                 ((req_i & ((NSRC'(1) << idx_o) - NSRC'(1))) == '0)));

endmodule

// File: rtl/irqc_svc.sv
module irqc_svc #(
  parameter int NSRC = 10,
  localparam int VW = (NSRC > 1) ? $clog2(NSRC) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            nest_en_i,
  input  logic            take_i,
  input  logic [VW-1:0]   take_idx_i,
  input  logic            rti_i,
  output logic [NSRC-1:0] allow_o,
  output logic            idle_o
);

  logic [NSRC-1:0] svc_q, svc_d;
  logic            svc_en;

  always_comb begin
    svc_d = svc_q;
    if (rti_i)  svc_d = svc_d & (svc_d - NSRC'(1));
    if (take_i) svc_d = svc_d | (NSRC'(1) << take_idx_i);
  end

  assign svc_en = rti_i | take_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      svc_q <= '0;
    else if (svc_en) svc_q <= svc_d;
  end

  assign idle_o = (svc_q == '0);

  always_comb begin
    logic acc;
    acc = 1'b0;
    for (int i = 0; i < NSRC; i++) begin
      acc        = acc | svc_q[i];
      allow_o[i] = nest_en_i ? ~acc : idle_o;
    end
  end

  // R11: a request is only taken when the service discipline allows it
  p_take_allowed_r11: assert property (@(posedge clk) disable iff (!rst_n)
    take_i |-> allow_o[take_idx_i]);

  // R12: a return alone retires exactly one service
  p_rti_pop_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (rti_i && !take_i && !idle_o) |=>
      ($countones(svc_q) == $countones($past(svc_q)) - 1));

endmodule

// File: rtl/irqc_top.sv
module irqc_top #(
  parameter int NSRC = 10,
  // 2 bits per source, index 0 in the low bits: 0 level, 1 edge, 2 configurable
  parameter logic [2*NSRC-1:0] SRC_KIND = 20'b00_01_01_10_10_01_00_00_10_01,
  parameter logic [NSRC-1:0]   NOMASK   = 10'b00_0000_0001,
  localparam int VW   = (NSRC > 1) ? $clog2(NSRC) : 1,
  localparam int NCFG = irqc_pkg::count_cfg(64'(SRC_KIND), NSRC),
  localparam int CW   = NCFG + 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] irq_i,
  input  logic            msk_we_i,
  input  logic [NSRC-1:0] msk_wdata_i,
  input  logic            ctl_we_i,
  input  logic [CW-1:0]   ctl_wdata_i,
  input  logic            fc_we_i,
  input  logic [NSRC-1:0] fc_force_i,
  input  logic [NSRC-1:0] fc_clear_i,
  input  logic            gie_set_i,
  input  logic            gie_clr_i,
  input  logic            ack_i,
  input  logic            rti_i,
  output logic            irq_valid_o,
  output logic [VW-1:0]   irq_vec_o
);
  import irqc_pkg::*;

  logic [NSRC-1:0] mask_q, mask_d;
  logic [CW-1:0]   ctl_q, ctl_d;
  logic            gie_q, gie_d, gie_en;
  logic            blank_q;
  logic            nest_q;

  logic [NSRC-1:0] pend, allow, req, take_vec;
  logic            pick_valid, take, svc_idle;
  logic [VW-1:0]   pick_idx;

  // ---------------- configuration registers ----------------
  always_comb begin
    mask_d = msk_we_i ? msk_wdata_i : mask_q;
    ctl_d  = ctl_we_i ? ctl_wdata_i : ctl_q;
    gie_d  = gie_clr_i ? 1'b0 : 1'b1;
    gie_en = gie_clr_i | gie_set_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        mask_q <= '0;
    else if (msk_we_i) mask_q <= mask_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        ctl_q <= '0;
    else if (ctl_we_i) ctl_q <= ctl_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      gie_q <= 1'b1;
    else if (gie_en) gie_q <= gie_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) blank_q <= 1'b0;
    else        blank_q <= msk_we_i;
  end

  assign nest_q = ctl_q[NCFG];

  // ---------------- per-source capture ----------------
  assign take_vec = take ? (NSRC'(1) << pick_idx) : '0;

  for (genvar g = 0; g < NSRC; g++) begin : g_src
    localparam logic [1:0] KIND = SRC_KIND[2*g +: 2];
    localparam int         RANK = count_cfg(64'(SRC_KIND), g);
    logic edge_mode;

    if (KIND == SRC_EDGE) begin : g_edge
      assign edge_mode = 1'b1;
    end else if (KIND == SRC_CFG) begin : g_cfg
      assign edge_mode = ctl_q[RANK];
    end else begin : g_level
      assign edge_mode = 1'b0;
    end

    irqc_src u_src (
      .clk         (clk),
      .rst_n       (rst_n),
      .irq_i       (irq_i[g]),
      .edge_mode_i (edge_mode),
      .force_i     (fc_we_i & fc_force_i[g]),
      .clear_i     (fc_we_i & fc_clear_i[g]),
      .take_i      (take_vec[g]),
      .pend_o      (pend[g])
    );
  end

  // ---------------- selection ----------------
  assign req = pend & (mask_q | NOMASK) & allow;

  irqc_pick #(.NSRC(NSRC)) u_pick (
    .clk     (clk),
    .rst_n   (rst_n),
    .req_i   (req),
    .valid_o (pick_valid),
    .idx_o   (pick_idx)
  );

  assign irq_valid_o = pick_valid & gie_q & ~blank_q;
  assign irq_vec_o   = pick_idx;
  assign take        = irq_valid_o & ack_i;

  irqc_svc #(.NSRC(NSRC)) u_svc (
    .clk        (clk),
    .rst_n      (rst_n),
    .nest_en_i  (nest_q),
    .take_i     (take),
    .take_idx_i (pick_idx),
    .rti_i      (rti_i),
    .allow_o    (allow),
    .idle_o     (svc_idle)
  );

  // R4: the cycle after a mask write presents nothing
  p_blank_after_mask_r4: assert property (@(posedge clk) disable iff (!rst_n)
    msk_we_i |=> !irq_valid_o);

  // R10: global disable silences the output
  p_global_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
    gie_clr_i |=> !irq_valid_o);

  // R2 / R9: a presented maskable source has its mask bit set
  p_mask_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_valid_o && !NOMASK[irq_vec_o]) |-> mask_q[irq_vec_o]);

  // R11: without nesting, presentation only happens with nothing in service
  p_serial_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_valid_o && !nest_q) |-> svc_idle);

endmodule

// File: tb/irqc_top_bench.sv
module irqc_top_bench;

  localparam int NSRC = 10;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [NSRC-1:0] irq = '0;
  logic            msk_we = 1'b0;
  logic [NSRC-1:0] msk_wdata = '0;
  logic            ctl_we = 1'b0;
  logic [3:0]      ctl_wdata = '0;
  logic            fc_we = 1'b0;
  logic [NSRC-1:0] fc_force = '0;
  logic [NSRC-1:0] fc_clear = '0;
  logic            gie_set = 1'b0;
  logic            gie_clr = 1'b0;
  logic            ack = 1'b0;
  logic            rti = 1'b0;
  logic            vld;
  logic [3:0]      vec;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  typedef struct {
    logic v;
    int   vec;
    int   rid;
  } exp_t;
  exp_t sbq[$];

  always #4 clk = ~clk;   // 125 MHz

  irqc_top u_irqc_top (
    .clk         (clk),
    .rst_n       (rst_n),
    .irq_i       (irq),
    .msk_we_i    (msk_we),
    .msk_wdata_i (msk_wdata),
    .ctl_we_i    (ctl_we),
    .ctl_wdata_i (ctl_wdata),
    .fc_we_i     (fc_we),
    .fc_force_i  (fc_force),
    .fc_clear_i  (fc_clear),
    .gie_set_i   (gie_set),
    .gie_clr_i   (gie_clr),
    .ack_i       (ack),
    .rti_i       (rti),
    .irq_valid_o (vld),
    .irq_vec_o   (vec)
  );

  // monitor: compare queued expectations at the falling edge
  always @(negedge clk) begin
    while (sbq.size() > 0) begin
      exp_t e;
      e = sbq.pop_front();
      total++;
      if (vld !== e.v || (e.v && vec !== 4'(e.vec))) begin
        bad++;
        $display("FAIL R%0d: got valid=%0b vec=%0d, expected valid=%0b vec=%0d",
                 e.rid, vld, vec, e.v, e.vec);
      end
    end
  end

  task automatic step();
    @(posedge clk); #1;
    msk_we = 1'b0; ctl_we = 1'b0; fc_we = 1'b0;
    fc_force = '0; fc_clear = '0;
    gie_set = 1'b0; gie_clr = 1'b0; ack = 1'b0; rti = 1'b0;
  endtask

  task automatic expect_out(input logic v, input int ev, input int rid);
    exp_t e;
    e.v = v; e.vec = ev; e.rid = rid;
    sbq.push_back(e);
    @(negedge clk); #1;
  endtask

  task automatic wr_mask(input logic [NSRC-1:0] m);
    msk_we = 1'b1; msk_wdata = m; step(); step();
  endtask

  task automatic serve();
    ack = 1'b1; step();
    rti = 1'b1; step();
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    step();
    expect_out(0, 0, 1);                 // R1 idle after reset
    irq[2] = 1'b1;
    step();
    expect_out(0, 0, 1);                 // R1 level source masked by reset
    irq[2] = 1'b0;

    // R9: power-down edge presented with mask all zero
    irq[0] = 1'b1; step(); irq[0] = 1'b0;
    expect_out(1, 0, 9);
    ack = 1'b1; step();
    expect_out(0, 0, 12);                // R12 in service, nothing offered
    rti = 1'b1; step();
    expect_out(0, 0, 12);                // R12 ack cleared the latch

    // R2 / R5 level source with mask open
    wr_mask('1);
    irq[3] = 1'b1;
    expect_out(1, 3, 5);
    // R4 blanking after a mask write
    msk_we = 1'b1; msk_wdata = '1; step();
    expect_out(0, 0, 4);
    step();
    expect_out(1, 3, 4);
    // R2 mask bit 3 cleared
    wr_mask(10'b11_1111_0111);
    expect_out(0, 0, 2);
    wr_mask('1);
    expect_out(1, 3, 2);
    // R3 priority
    irq[2] = 1'b1;
    expect_out(1, 2, 3);
    irq[2] = 1'b0;
    expect_out(1, 3, 5);
    irq[3] = 1'b0;
    expect_out(0, 0, 5);

    // R6 fixed edge source 4
    irq[4] = 1'b1; step(); irq[4] = 1'b0;
    expect_out(1, 4, 6);
    step();
    expect_out(1, 4, 6);
    ack = 1'b1; step();
    expect_out(0, 0, 11);
    rti = 1'b1; step();
    expect_out(0, 0, 6);

    // R7 configurable source 1: level then edge mode
    irq[1] = 1'b1;
    expect_out(1, 1, 7);
    irq[1] = 1'b0;
    expect_out(0, 0, 7);
    ctl_we = 1'b1; ctl_wdata = 4'b0001; step();
    irq[1] = 1'b1; step(); irq[1] = 1'b0;
    expect_out(1, 1, 7);
    serve();
    expect_out(0, 0, 7);

    // R8 force / clear
    fc_we = 1'b1; fc_force[4] = 1'b1; step();
    expect_out(1, 4, 8);
    fc_we = 1'b1; fc_clear[4] = 1'b1; step();
    expect_out(0, 0, 8);
    fc_we = 1'b1; fc_force[2] = 1'b1; step();
    expect_out(0, 0, 8);                 // R8 force ignored on level source

    // R10 global disable blocks power-down too
    gie_clr = 1'b1; step();
    fc_we = 1'b1; fc_force[0] = 1'b1; step();
    expect_out(0, 0, 10);
    gie_set = 1'b1; step();
    expect_out(1, 0, 10);
    serve();

    // R11 no nesting: serial service
    irq[3] = 1'b1;
    expect_out(1, 3, 11);
    ack = 1'b1; step();
    expect_out(0, 0, 11);
    irq[2] = 1'b1;
    expect_out(0, 0, 11);
    rti = 1'b1; step();
    expect_out(1, 2, 11);
    // R11 nesting on
    ctl_we = 1'b1; ctl_wdata = 4'b1001; step();
    ack = 1'b1; step();
    expect_out(0, 0, 11);
    fc_we = 1'b1; fc_force[0] = 1'b1; step();
    expect_out(1, 0, 11);                // higher priority preempts
    ack = 1'b1; step();
    expect_out(0, 0, 11);
    rti = 1'b1; step();
    expect_out(0, 0, 11);                // source 2 still in service
    rti = 1'b1; step();
    expect_out(1, 2, 12);
    irq[2] = 1'b0; irq[3] = 1'b0;
    expect_out(0, 0, 5);

    // R9 again with mask fully closed
    wr_mask('0);
    fc_we = 1'b1; fc_force[0] = 1'b1; step();
    expect_out(1, 0, 9);
    serve();
    expect_out(0, 0, 9);

    step();
    done = 1'b1;
  end

  initial begin
    int cyc;
    cyc = 0;
    while (!done && cyc < 20000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: got timeout, expected completion");
    end
    @(negedge clk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule